// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Command-Injected Characters

This block drives one asynchronous serial line for byte-stuffed HDLC/PPP style traffic. The host queues bytes into a transmit FIFO, and each byte carries a flag that marks the end of a frame. On each baud enable, the transmitter sends the bytes as 10-bit characters. Each character has a start bit of 0, eight data bits with the least significant bit first, and a stop bit of 1.

A byte-wide command register lets the host put special characters ahead of everything still queued. The commands are:
- An abort, which sends an escape/flag pair and then drops the rest of the current frame.
- A flow-control character, either start (0x11) or stop (0x13).
- A test mode that sends the next queued byte with a bad stop bit.

The register clears itself once the requested action has gone out. A separate clear pulse flushes the queue, the command and the transmit status, but keeps the enable setting. Injection is only decided at character boundaries, so a character already on the line always finishes.

Top module: `async_tx_inject`

## Requirements
- R1: After reset the line `txd` is 1, `cmd_q` is 0x00, the FIFO is empty, `tx_enabled` is 0 and `eof_sent` is 0.
- R2: Queued bytes go out in queue order. Each is 10 baud ticks long: a 0 start bit, data bits 0 to 7, then a stop bit of 1. The line idles at 1 between characters.
- R3: Command value 0x0A sends 0x11, and command value 0x09 sends 0x13. In both cases the character is sent before any byte already in the FIFO, and the queued bytes then follow unchanged. Send-special is bit 3, start is bit 1 and stop is bit 0.
- R4: After an injected flow-control character or a bad-stop character has been started, `cmd_q` reads 0x00.
- R5: Bits 2, 1 and 0 have no effect while bit 3 is clear. Queued bytes go out normally and `cmd_q` keeps the written value.
- R6: Bits 7, 5 and 4 of the command register always read 0, whatever is written to them.
- R7: Command bit 6 (abort) sends 0x7D and then 0x7E ahead of the queue. After that, every queued byte up to and including the next one flagged end-of-frame is dropped, including bytes written while the drop is in progress. Later frames are sent normally.
- R8: Command value 0x0C (bits 3 and 2) sends the next queued byte with a stop bit of 0. The byte after it has a normal stop bit, and the transmission continues.
- R9: When abort and a send-special request are set together, only the abort pair is sent. The whole register reads 0x00 after the 0x7E.
- R10: A `clr_tx` pulse empties the FIFO, zeroes `cmd_q` and `eof_sent`, and leaves `tx_enabled` unchanged. Bytes flushed by the pulse are never sent.
- R11: While `tx_enabled` is 0 no new character starts. Setting it to 1 lets the queue drain.
- R12: `eof_sent` becomes 1 once a byte flagged end-of-frame has been started on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| fifo_we | input | 1 | Push a byte into the transmit FIFO |
| fifo_wdata | input | 8 | Byte to push |
| fifo_weof | input | 1 | Pushed byte ends a frame |
| fifo_full | output | 1 | FIFO cannot take a byte |
| fifo_empty | output | 1 | FIFO holds no byte |
| cmd_we | input | 1 | Write the command register |
| cmd_wdata | input | 8 | Command value |
| cmd_q | output | 8 | Command register contents |
| en_we | input | 1 | Write the transmit enable |
| en_wdata | input | 1 | New transmit enable value |
| tx_enabled | output | 1 | Transmit enable |
| clr_tx | input | 1 | Clear-transmitter pulse |
| eof_sent | output | 1 | Sticky: an end-of-frame byte was started |
| txd | output | 1 | Serial line |

## Verification
Two things can happen in the same clock cycle: the frame drop after an abort removes a FIFO entry while the host writes a new one. The bench provokes this by starting an abort on an empty queue. Once the 0x7D has been received, it pushes three bytes on consecutive cycles, the last one flagged end-of-frame, and then a marked fourth frame. The result is judged at the line: after the 0x7E only the fourth byte may appear, and the queue must end empty. A lost or doubled count would either leak a dropped byte or hide the fourth one.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  // command bit positions (software-visible layout)
  localparam int unsigned CB_ABORT = 6;
  localparam int unsigned CB_SPCL  = 3;
  localparam int unsigned CB_BADSP = 2;
  localparam int unsigned CB_START = 1;
  localparam int unsigned CB_STOP  = 0;
  localparam logic [7:0] CMD_WMASK = 8'h4F;

  localparam logic [7:0] CH_ESC   = 8'h7D;
  localparam logic [7:0] CH_FLAG  = 8'h7E;
  localparam logic [7:0] CH_START = 8'h11;
  localparam logic [7:0] CH_STOP  = 8'h13;

  typedef struct packed {
    logic       eof;
    logic [7:0] data;
  } txq_entry_t;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  a_r2_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> full);
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/tx_cmd_ctrl.sv
module tx_cmd_ctrl
  import async_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wdata,
  output logic [7:0] cmd_q,
  input  logic       start_ok,
  input  logic       fifo_empty,
  input  txq_entry_t fifo_head,
  output logic       fifo_pop,
  output logic       ld,
  output logic [7:0] ld_data,
  output logic       ld_bad,
  output logic       eof_sent
);
  logic [7:0] cmd_r;
  logic       esc_done, dropping, eof_r;
  logic       abort_on, spcl_on, take_fifo, spcl_char;

  assign abort_on = cmd_r[CB_ABORT];
  assign spcl_on  = cmd_r[CB_SPCL];

  always_comb begin
    ld        = 1'b0;
    ld_data   = 8'h00;
    ld_bad    = 1'b0;
    take_fifo = 1'b0;
    spcl_char = 1'b0;
    if (start_ok) begin
      if (abort_on) begin
        ld      = 1'b1;
        ld_data = esc_done ? CH_FLAG : CH_ESC;
      end else if (spcl_on && cmd_r[CB_START]) begin
        ld        = 1'b1;
        ld_data   = CH_START;
        spcl_char = 1'b1;
      end else if (spcl_on && cmd_r[CB_STOP]) begin
        ld        = 1'b1;
        ld_data   = CH_STOP;
        spcl_char = 1'b1;
      end else if (!dropping && !fifo_empty) begin
        ld        = 1'b1;
        ld_data   = fifo_head.data;
        ld_bad    = spcl_on && cmd_r[CB_BADSP];
        take_fifo = 1'b1;
      end
    end
  end

  assign fifo_pop = take_fifo || (dropping && !fifo_empty);
  assign cmd_q    = cmd_r;
  assign eof_sent = eof_r;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cmd_r    <= 8'h00;
      esc_done <= 1'b0;
      dropping <= 1'b0;
      eof_r    <= 1'b0;
    end else begin
      if (dropping && !fifo_empty && fifo_head.eof) dropping <= 1'b0;
      if (ld && abort_on) begin
        if (esc_done) begin
          esc_done <= 1'b0;
          dropping <= 1'b1;
          cmd_r    <= 8'h00;
        end else begin
          esc_done <= 1'b1;
        end
      end
      if (spcl_char || (take_fifo && ld_bad)) cmd_r <= 8'h00;
      if (take_fifo && fifo_head.eof) eof_r <= 1'b1;
      if (cmd_we) begin
        cmd_r    <= cmd_wdata & CMD_WMASK;
        esc_done <= 1'b0;
      end
    end
  end

  a_r4_special_clears: assert property (@(posedge clk) disable iff (rst)
    (start_ok && cmd_q[CB_SPCL] && (cmd_q[CB_START] || cmd_q[CB_STOP]) &&
     !cmd_q[CB_ABORT] && !cmd_we && !clr) |=> (cmd_q == 8'h00));
  a_r9_abort_survives_escape: assert property (@(posedge clk) disable iff (rst)
    (ld && ld_data == CH_ESC && abort_on && !cmd_we && !clr) |=> cmd_q[CB_ABORT]);
  a_r7_drop_pops: assert property (@(posedge clk) disable iff (rst)
    (dropping && !fifo_empty) |-> (fifo_pop && !ld_bad));
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 tick,
  input  logic                 ld,
  input  logic [DATA_BITS-1:0] ld_data,
  input  logic                 ld_bad,
  output logic                 busy,
  output logic                 txd
);
  localparam int unsigned REMAIN = DATA_BITS + 1;
  localparam int unsigned CNTW   = $clog2(REMAIN + 1);

  logic [DATA_BITS:0] sh;
  logic [CNTW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      cnt  <= '0;
      sh   <= '1;
    end else if (tick) begin
      if (busy) begin
        txd <= sh[0];
        sh  <= {1'b1, sh[DATA_BITS:1]};
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) busy <= 1'b0;
      end else if (ld) begin
        txd  <= 1'b0;
        sh   <= {~ld_bad, ld_data};
        cnt  <= CNTW'(REMAIN);
        busy <= 1'b1;
      end else begin
        txd <= 1'b1;
      end
    end
  end

  a_r2_idle_marks: assert property (@(posedge clk) disable iff (rst)
    (tick && !busy && !ld && !clr) |=> txd);
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    (tick && !busy && ld && !clr) |=> (!txd && busy));
endmodule

// File: rtl/async_tx_inject.sv
module async_tx_inject
  import async_tx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       fifo_we,
  input  logic [7:0] fifo_wdata,
  input  logic       fifo_weof,
  output logic       fifo_full,
  output logic       fifo_empty,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wdata,
  output logic [7:0] cmd_q,
  input  logic       en_we,
  input  logic       en_wdata,
  output logic       tx_enabled,
  input  logic       clr_tx,
  output logic       eof_sent,
  output logic       txd
);
  localparam int unsigned ENTRY_W = $bits(txq_entry_t);

  txq_entry_t push_ent, head_ent;
  logic       pop, busy, start_ok, ld, ld_bad, en_r;
  logic [7:0] ld_data;

  assign push_ent   = '{eof: fifo_weof, data: fifo_wdata};
  assign start_ok   = baud_tick && !busy && en_r;
  assign tx_enabled = en_r;

  always_ff @(posedge clk) begin
    if (rst)        en_r <= 1'b0;
    else if (en_we) en_r <= en_wdata;
  end

  tx_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(clr_tx),
    .push(fifo_we), .push_data(push_ent),
    .pop(pop), .head(head_ent),
    .empty(fifo_empty), .full(fifo_full)
  );

  tx_cmd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clr(clr_tx),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
    .start_ok(start_ok), .fifo_empty(fifo_empty), .fifo_head(head_ent),
    .fifo_pop(pop), .ld(ld), .ld_data(ld_data), .ld_bad(ld_bad),
    .eof_sent(eof_sent)
  );

  tx_shifter #(.DATA_BITS(8)) u_shift (
    .clk(clk), .rst(rst), .clr(clr_tx), .tick(baud_tick),
    .ld(ld), .ld_data(ld_data), .ld_bad(ld_bad),
    .busy(busy), .txd(txd)
  );

  a_r11_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_r |-> !ld);
  a_r10_enable_kept: assert property (@(posedge clk) disable iff (rst)
    (clr_tx && !en_we) |=> $stable(tx_enabled));
  a_r6_reserved_low: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> (cmd_q[7] == 1'b0 && cmd_q[5:4] == 2'b00));
endmodule

// File: tb/tb_async_tx_inject.sv
module tb_async_tx_inject;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0;
  logic fifo_we = 1'b0, fifo_weof = 1'b0, cmd_we = 1'b0, en_we = 1'b0;
  logic en_wdata = 1'b0, clr_tx = 1'b0;
  logic [7:0] fifo_wdata = 8'h00, cmd_wdata = 8'h00;
  logic fifo_full, fifo_empty, tx_enabled, eof_sent, txd;
  logic [7:0] cmd_q;

  int tests = 0, fails = 0;
  logic [8:0] rx_q[$];
  logic [8:0] exp_q[$];
  int   tdiv = 0;
  bit   mon_busy = 0;
  int   mon_n = 0;
  logic [7:0] mon_byte = 8'h00;

  localparam logic [7:0] VEC [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h7E, 8'h3C};

  always #5 clk = ~clk;

  async_tx_inject #(.FIFO_DEPTH(16)) dut (.*);

  // tick generation and line decoder, both on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      mon_busy = 0; mon_n = 0;
    end else if (baud_tick) begin
      if (!mon_busy) begin
        if (txd == 1'b0) begin mon_busy = 1; mon_n = 0; end
      end else begin
        if (mon_n < 8) mon_byte[mon_n] = txd;
        else begin rx_q.push_back({txd, mon_byte}); mon_busy = 0; end
        mon_n++;
      end
    end
    baud_tick = (tdiv == TICK_DIV - 1);
    tdiv = (tdiv + 1) % TICK_DIV;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic e);
    fifo_we = 1'b1; fifo_wdata = d; fifo_weof = e;
    @(negedge clk);
    fifo_we = 1'b0; fifo_weof = 1'b0;
  endtask

  task automatic wcmd(input logic [7:0] v);
    cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wen(input logic v);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic expect_line(input string req);
    int guard = 0;
    while (rx_q.size() < exp_q.size() && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (60) @(negedge clk);
    chk(rx_q.size() == exp_q.size(), req, rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++)
      if (i < rx_q.size()) chk(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
    rx_q.delete(); exp_q.delete();
  endtask

  task automatic pause();
    wen(1'b0);
    rx_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(cmd_q == 8'h00, "R1 cmd_q", cmd_q, 0);
    chk(fifo_empty && !tx_enabled && !eof_sent, "R1 flags",
        {fifo_empty, tx_enabled, eof_sent}, 3'b100);

    // R2 table walk: plain queued bytes
    foreach (VEC[i]) begin
      push(VEC[i], 1'b0);
      exp_q.push_back({1'b1, VEC[i]});
    end
    // R11 disabled: nothing leaves
    repeat (100) @(negedge clk);
    chk(rx_q.size() == 0, "R11 disabled", rx_q.size(), 0);
    wen(1'b1);
    expect_line("R2 table");
    chk(fifo_empty, "R2 drained", fifo_empty, 1);
    pause();

    // R6 reserved bits
    wcmd(8'hB0);
    chk(cmd_q == 8'h00, "R6 reserved", cmd_q, 8'h00);

    // R5 modifiers without send-special
    push(8'h41, 1'b0); push(8'h42, 1'b0);
    wcmd(8'h07);
    exp_q.push_back({1'b1, 8'h41}); exp_q.push_back({1'b1, 8'h42});
    wen(1'b1);
    expect_line("R5 no effect");
    chk(cmd_q == 8'h07, "R5 cmd kept", cmd_q, 8'h07);
    pause(); wcmd(8'h00);

    // R3 start character ahead of queue, R4 self-clear
    push(8'h55, 1'b0); push(8'h66, 1'b0);
    wcmd(8'h0A);
    exp_q.push_back({1'b1, 8'h11}); exp_q.push_back({1'b1, 8'h55});
    exp_q.push_back({1'b1, 8'h66});
    wen(1'b1);
    expect_line("R3 start char");
    chk(cmd_q == 8'h00, "R4 cleared after 0x11", cmd_q, 0);
    pause();

    // R3 stop character
    push(8'hC3, 1'b0);
    wcmd(8'h09);
    exp_q.push_back({1'b1, 8'h13}); exp_q.push_back({1'b1, 8'hC3});
    wen(1'b1);
    expect_line("R3 stop char");
    chk(cmd_q == 8'h00, "R4 cleared after 0x13", cmd_q, 0);
    pause();

    // R8 bad stop on next byte only
    push(8'h31, 1'b0); push(8'h32, 1'b0);
    wcmd(8'h0C);
    exp_q.push_back({1'b0, 8'h31}); exp_q.push_back({1'b1, 8'h32});
    wen(1'b1);
    expect_line("R8 bad stop");
    chk(cmd_q == 8'h00, "R4 cleared after bad stop", cmd_q, 0);
    pause();

    // R7 abort drops rest of frame, R12 eof status
    chk(!eof_sent, "R12 before eof", eof_sent, 0);
    push(8'h10, 1'b0); push(8'h20, 1'b0); push(8'h30, 1'b1);
    push(8'h40, 1'b0); push(8'h50, 1'b1);
    wcmd(8'h40);
    exp_q.push_back({1'b1, 8'h7D}); exp_q.push_back({1'b1, 8'h7E});
    exp_q.push_back({1'b1, 8'h40}); exp_q.push_back({1'b1, 8'h50});
    wen(1'b1);
    expect_line("R7 abort");
    chk(eof_sent, "R12 eof seen", eof_sent, 1);
    chk(cmd_q == 8'h00, "R7 cmd cleared", cmd_q, 0);
    pause();

    // R9 abort wins over start request
    push(8'h61, 1'b1); push(8'h62, 1'b1);
    wcmd(8'h4A);
    exp_q.push_back({1'b1, 8'h7D}); exp_q.push_back({1'b1, 8'h7E});
    exp_q.push_back({1'b1, 8'h62});
    wen(1'b1);
    expect_line("R9 priority");
    chk(cmd_q == 8'h00, "R9 cmd cleared", cmd_q, 0);

    // R7 drop with pushes in the same cycles as drop pops
    rx_q.delete(); exp_q.delete();
    wcmd(8'h40);
    while (rx_q.size() < 1) @(negedge clk);
    repeat (48) @(negedge clk); // 0x7E now loaded, drop active
    push(8'h01, 1'b0); push(8'h02, 1'b0); push(8'h03, 1'b1);
    push(8'h77, 1'b1);
    exp_q.push_back({1'b1, 8'h7D}); exp_q.push_back({1'b1, 8'h7E});
    exp_q.push_back({1'b1, 8'h77});
    expect_line("R7 drop during push");
    chk(fifo_empty, "R7 queue empty", fifo_empty, 1);
    pause();

    // R10 clear with enable off
    push(8'hAA, 1'b0); push(8'hBB, 1'b0); push(8'hCC, 1'b1);
    wcmd(8'h0A);
    clr_tx = 1'b1; @(negedge clk); clr_tx = 1'b0;
    chk(fifo_empty, "R10 fifo empty", fifo_empty, 1);
    chk(cmd_q == 8'h00, "R10 cmd zero", cmd_q, 0);
    chk(!eof_sent, "R10 status zero", eof_sent, 0);
    chk(!tx_enabled, "R10 enable kept off", tx_enabled, 0);
    wen(1'b1);
    repeat (200) @(negedge clk);
    chk(rx_q.size() == 0, "R10 flushed not sent", rx_q.size(), 0);
    clr_tx = 1'b1; @(negedge clk); clr_tx = 1'b0;
    chk(tx_enabled, "R10 enable kept on", tx_enabled, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule